// File: doc/BRIEF.md
# Change-of-State Digital Input Controller

This block takes 48 input-only digital lines and exposes them through an 8-byte, byte-wide register window. The lines form six groups of eight. Software reads the live, synchronized level of each group through its own byte offset. Each group can be armed so that a transition in either direction on any of its eight lines is latched as a pending change and raises an interrupt request.

The block has no output drivers and no direction control. Every channel is an input. Per-pin masking is left to software: the hardware reports only which group changed. Software reads one control/status byte to learn which groups changed and whether this block is asserting its interrupt. That read also acknowledges the pending changes. Writing the same byte sets the group enable mask.

Top module: `cosin_ctrl`

## Requirements
- R1: After synchronous reset, the enable mask and all group status bits are zero, `irq` is low, and offset 7 reads 0x40.
- R2: Offsets 0, 1, 2, 4, 5 and 6 return input groups 0 to 5 in that order. Bit 0 of each byte is the lowest channel of its group (offset 0 bit 0 is `din[0]`, offset 6 bit 7 is `din[47]`). A level applied at `din` is readable two clock edges later.
- R3: Offset 3 always reads 0x00.
- R4: A write to offset 7 loads bits 5:0 as the group enable mask. When group n is enabled, a rising or falling change on any of its lines sets status bit n and drives `irq` high on the third clock edge after the change is applied.
- R5: Changes on lines of a group whose enable bit is 0 set no status bit and leave `irq` unchanged.
- R6: Reading offset 7 returns the group status in bits 5:0. Bit 6 is 0 while `irq` is high and 1 otherwise. Bit 7 is always 0.
- R7: Status bits stay set until a read strobe at offset 7. That read clears them, and `irq` falls after that edge.
- R8: If a new change is detected in the same cycle as a clearing read, its status bit is set after the read and `irq` stays high.
- R9: Writing 0 to the enable bit of a group with pending status clears that status bit.
- R10: Writes to offsets 0 to 6 change neither the enable mask, the status bits, nor the live input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe. At offset 7 it acknowledges status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| din | input | 48 | Asynchronous digital input lines |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench applies a new change exactly one cycle before a clearing read. A design that acknowledges blindly would lose that change and drop `irq`. It also disables a group that has a pending bit, to catch a design that keeps a stale status which software can no longer clear through the mask. It toggles lines in disabled groups and writes to data offsets and the gap byte. A decoder that aliases offset 3, or lets data writes reach the mask, would fire an interrupt or change the status byte. The bench also sends a fall on one line and a rise on another in the same group, and walks single lines across group boundaries. A design that detects only one edge direction, or maps offsets 4 to 6 wrongly, would report the wrong group.

// File: rtl/cosin_pkg.sv
package cosin_pkg;

    localparam int GRP_W    = 8;
    localparam int NUM_GRP  = 6;
    localparam int ADDR_W   = 3;
    localparam int NUM_CH   = GRP_W * NUM_GRP;
    localparam int IDX_W    = $clog2(NUM_GRP);

    localparam logic [ADDR_W-1:0] GAP_OFS  = 3'd3;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 3'd7;

    // result of decoding a byte offset onto an input group
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } grp_sel_t;

    // layout of the control/status read byte
    typedef struct packed {
        logic               zero7;
        logic               irq_n;
        logic [NUM_GRP-1:0] grp;
    } ctrl_rd_t;

    // offsets below the gap map directly, those above it shift down by one
    function automatic grp_sel_t decode_grp(input logic [ADDR_W-1:0] ofs);
        grp_sel_t s;
        s.hit = 1'b0;
        s.idx = '0;
        if (ofs < GAP_OFS) begin
            s.hit = 1'b1;
            s.idx = IDX_W'(ofs);
        end else if (ofs > GAP_OFS && ofs < CTRL_OFS) begin
            s.hit = 1'b1;
            s.idx = IDX_W'(ofs - 3'd1);
        end
        return s;
    endfunction

endpackage

// File: rtl/cosin_sync.sv
module cosin_sync #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/cosin_edge.sv
module cosin_edge #(
    parameter int GRP_W   = 8,
    parameter int NUM_GRP = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [GRP_W*NUM_GRP-1:0] cur_i,
    output logic [NUM_GRP-1:0]       grp_hit_o
);

    localparam int W = GRP_W * NUM_GRP;

    logic [W-1:0] prev_q;
    logic [W-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur_i;
    end

    // a difference either way counts as a change
    assign diff = cur_i ^ prev_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_hit_o[g] = |diff[g*GRP_W +: GRP_W];
    end

endmodule

// File: rtl/cosin_status.sv
module cosin_status #(
    parameter int NUM_GRP = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr_i,
    input  logic [NUM_GRP-1:0] en_wdata_i,
    input  logic               clr_i,
    input  logic [NUM_GRP-1:0] grp_hit_i,
    output logic [NUM_GRP-1:0] status_o,
    output logic               irq_o
);

    logic [NUM_GRP-1:0] en_q;
    logic [NUM_GRP-1:0] en_nxt;
    logic [NUM_GRP-1:0] status_q;
    logic [NUM_GRP-1:0] status_nxt;

    always_comb begin
        en_nxt     = ctl_wr_i ? en_wdata_i : en_q;
        status_nxt = clr_i ? '0 : status_q;
        status_nxt = (status_nxt | grp_hit_i) & en_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            status_q <= '0;
        end else begin
            en_q     <= en_nxt;
            status_q <= status_nxt;
        end
    end

    assign status_o = status_q;
    assign irq_o    = |status_q;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o);                                                       // R1
    AST_ENABLED_HIT_RAISES: assert property (@(posedge clk) disable iff (rst)
        (|(grp_hit_i & en_q) && !ctl_wr_i) |=> irq_o);                               // R4
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr_i && !clr_i) |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0)); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !ctl_wr_i) |=> ((status_q & $past(status_q)) == $past(status_q))); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && grp_hit_i == '0) |=> !irq_o);                                       // R7
    AST_NEW_EDGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !ctl_wr_i) |=> (status_q == $past(grp_hit_i & en_q)));             // R8
    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_i |=> ((status_q & ~$past(en_wdata_i)) == '0));                       // R9

endmodule

// File: rtl/cosin_ctrl.sv
module cosin_ctrl
    import cosin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_CH-1:0] din,
    output logic              irq
);

    logic [NUM_CH-1:0]  din_sync;
    logic [NUM_GRP-1:0] grp_hit;
    logic [NUM_GRP-1:0] status;
    logic               ctl_wr;
    logic               ctl_clr;
    grp_sel_t           sel;
    ctrl_rd_t           ctrl_byte;

    cosin_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (din),
        .sync_o  (din_sync)
    );

    cosin_edge #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .cur_i     (din_sync),
        .grp_hit_o (grp_hit)
    );

    assign ctl_wr  = bus_wr && (bus_addr == CTRL_OFS);
    assign ctl_clr = bus_rd && (bus_addr == CTRL_OFS);

    cosin_status #(.NUM_GRP(NUM_GRP)) u_status (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr_i   (ctl_wr),
        .en_wdata_i (bus_wdata[NUM_GRP-1:0]),
        .clr_i      (ctl_clr),
        .grp_hit_i  (grp_hit),
        .status_o   (status),
        .irq_o      (irq)
    );

    always_comb begin
        sel             = decode_grp(bus_addr);
        ctrl_byte.zero7 = 1'b0;
        ctrl_byte.irq_n = ~irq;
        ctrl_byte.grp   = status;
        if (bus_addr == CTRL_OFS)
            bus_rdata = ctrl_byte;
        else if (sel.hit)
            bus_rdata = din_sync[sel.idx*GRP_W +: GRP_W];
        else
            bus_rdata = '0;
    end

    AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == GAP_OFS) |-> (bus_rdata == 8'h00));                 // R3
    AST_IRQ_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_OFS) |-> (bus_rdata[6] == !irq && !bus_rdata[7])); // R6

endmodule

// File: tb/cosin_ctrl_tb.sv
`timescale 1ns/1ps
module cosin_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [47:0] din;
    logic        irq;

    int n_vec  = 0;
    int n_fail = 0;

    logic [47:0] pins_m;
    logic [5:0]  en_m;
    logic [5:0]  st_m;

    always #4 clk = ~clk;

    cosin_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .irq(irq)
    );

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return pins_m[7:0];
            3'd1: return pins_m[15:8];
            3'd2: return pins_m[23:16];
            3'd3: return 8'h00;
            3'd4: return pins_m[31:24];
            3'd5: return pins_m[39:32];
            3'd6: return pins_m[47:40];
            default: return {1'b0, (st_m == 6'd0), st_m};
        endcase
    endfunction

    function automatic logic [5:0] changed_grps(input logic [47:0] a, input logic [47:0] b);
        logic [5:0] c;
        for (int g = 0; g < 6; g++) c[g] = (a[g*8 +: 8] != b[g*8 +: 8]);
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic check_reg(input logic [2:0] a, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata === exp_rd(a), tag, {24'd0, bus_rdata}, {24'd0, exp_rd(a)});
        check(irq === (st_m != 6'd0), tag, {31'd0, irq}, {31'd0, (st_m != 6'd0)});
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) check_reg(3'(a), tag);
    endtask

    // pins applied at a falling edge are latched on the third rising edge
    task automatic apply_pins(input logic [47:0] nv);
        logic [5:0] c;
        c = changed_grps(pins_m, nv);
        din = nv;
        repeat (3) @(negedge clk);
        pins_m = nv;
        st_m = st_m | (c & en_m);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 3'd7) begin
            en_m = d[5:0];
            st_m = st_m & en_m;
        end
    endtask

    task automatic read_clear(input string tag);
        bus_addr = 3'd7; bus_rd = 1'b1;
        #1;
        check(bus_rdata === exp_rd(3'd7), tag, {24'd0, bus_rdata}, {24'd0, exp_rd(3'd7)});
        @(negedge clk);
        bus_rd = 1'b0;
        st_m = '0;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] nv;
        void'($urandom(32'h5EED_C05));
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; din = '0;
        pins_m = '0; en_m = '0; st_m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check_reg(3'd7, "R1");
        check(bus_rdata === 8'h40, "R1", {24'd0, bus_rdata}, 32'h40);

        // R5: changes with nothing enabled
        apply_pins(48'hA5A5_5A5A_F00F);
        check_all("R5");
        // R2: walking single lines across all groups
        for (int i = 0; i < 48; i += 7) begin
            apply_pins(48'd1 << i);
            check_all("R2");
        end
        apply_pins(48'h8000_0000_0001);
        check_reg(3'd6, "R2");
        check_reg(3'd0, "R2");

        // R4: enable groups 0 and 4, rise on group 4
        bus_write(3'd7, 8'hD1);
        check_reg(3'd7, "R4");
        apply_pins(48'h8001_0000_0001);
        check_reg(3'd7, "R4");
        // R7: sticky until read strobe
        repeat (5) @(negedge clk);
        check_reg(3'd7, "R7");
        read_clear("R7");
        check_reg(3'd7, "R7");
        // R4: falling edge only, plus mixed rise/fall in one group
        apply_pins(48'h8001_0000_0000);
        check_reg(3'd7, "R4");
        read_clear("R6");
        apply_pins(48'h8001_0000_0002);
        apply_pins(48'h8001_0000_0004);
        check_reg(3'd7, "R4");

        // R8: new change in group 1 during clearing read
        bus_write(3'd7, 8'h03);
        check_reg(3'd7, "R8");
        nv = pins_m ^ 48'h0000_0000_0100;
        din = nv;
        repeat (2) @(negedge clk);
        bus_addr = 3'd7; bus_rd = 1'b1;
        #1;
        check(bus_rdata === 8'h01, "R8", {24'd0, bus_rdata}, 32'h01);
        @(negedge clk);
        bus_rd = 1'b0;
        pins_m = nv;
        st_m = 6'b000010;
        check_reg(3'd7, "R8");

        // R10: writes to data offsets and the gap
        for (int a = 0; a < 7; a++) bus_write(3'(a), 8'hFF);
        check_all("R10");
        apply_pins(pins_m ^ 48'h0100_0000_0000);
        check_reg(3'd7, "R10");
        // R9: disabling a pending group clears it
        apply_pins(pins_m ^ 48'h0000_0000_0001);
        check_reg(3'd7, "R9");
        bus_write(3'd7, 8'h02);
        check_reg(3'd7, "R9");
        bus_write(3'd7, 8'h00);
        check_reg(3'd7, "R9");

        // random mix
        for (int it = 0; it < 200; it++) begin
            case ($urandom % 4)
                0, 1: begin
                    nv = pins_m;
                    for (int g = 0; g < 6; g++)
                        if ($urandom % 3 == 0) nv[g*8 +: 8] = 8'($urandom);
                    apply_pins(nv);
                end
                2: bus_write(3'($urandom % 8), 8'($urandom));
                default: read_clear("R6");
            endcase
            check_all("R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule